// File: doc/BRIEF.md
# Machine-Cycle T-State Sequencer

This block walks a processor through the states of each machine cycle. Every cycle opens with T1 and T2. Then come zero or more TW wait states while memory holds READY low, then T3, and then T4 and T5 only when the cycle needs them. A separate input gives the number of active states in the current cycle, and the sequencer leaves the cycle after T3, T4 or T5 to match it. The sequencer moves one state per phi1-rate tick. It decodes no instructions. The surrounding decode logic tells it the per-cycle state count, whether the current cycle closes an instruction, and whether a halt instruction was just executed.

Outside normal cycles the sequencer has two more states: a bus-hold state and a halt state. A hold request is taken only where a machine cycle ends. During hold, the acknowledge output and the bus-float output are both high. A halt instruction parks the sequencer in the halt state after T2 of the following machine cycle. Three things can take it out of halt:
- Reset.
- A hold, which returns to halt once the hold request goes away.
- An enabled interrupt, which starts an interrupt machine cycle.

An enabled interrupt is latched only in the last state of an instruction. The machine cycle that follows is flagged as an interrupt cycle, and the program counter does not advance in it.

Top module: `tstate_sequencer`

## Requirements
- R1: With `rst` high at a clock edge, whatever the value of `tick`, the state becomes T1 and the interrupt-cycle flag, any pending halt and any memory of hold-from-halt are cleared. Reset wins over `holdReq`, including in the hold state.
- R2: The state changes only on clock edges where `tick` is high. With `tick` low the state holds.
- R3: The `state` encoding is T1=0, T2=1, TW=2, T3=3, T4=4, T5=5, HALT=6, HOLD=7. T1 is followed by T2. From T2, `ready` high leads to T3 and `ready` low leads to TW. TW repeats while `ready` is low and goes to T3 on the first tick with `ready` high. No other state leads to TW.
- R4: The machine cycle ends after T3 when `stateCount` ≤ 3, after T4 when it is 4, and after T5 when it is 5 or more. It then goes straight to T1.
- R5: `sync` is high exactly while the state is T1. `pcIncEn` is high in T1 except in an interrupt cycle.
- R6: A hold request is taken only on the tick that ends a machine cycle, going to HOLD instead of T1. `holdReq` in T1, T2 or TW does not cut a cycle short. In HOLD, `hlda` and `busFloat` are high. HOLD lasts while `holdReq` is high, and then returns to T1, or to HALT if the hold was entered from HALT.
- R7: On the tick that ends a machine cycle, `intCycle` is loaded with `lastCycle & intReq & intEnable`. The value is kept through any hold that follows. While `intCycle` is high, `pcIncEn` is low in T1.
- R8: If `haltInstr` is high on the tick that ends a machine cycle, the next machine cycle runs T1, T2 and then enters HALT, whatever `ready` is. In HALT, `haltAck` and `busFloat` are high and `hlda` is low.
- R9: HALT is left only by reset, by `holdReq` (to HOLD, and back to HALT afterwards), or by `intReq` with `intEnable` high, which goes to T1 with `intCycle` high. `intReq` with `intEnable` low leaves HALT unchanged.
- R10: When requests coincide, reset comes before hold, and hold comes before interrupt. In HALT with both `holdReq` and an enabled `intReq`, the next state is HOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset to T1, active high |
| tick | input | 1 | Phi1-rate state advance enable |
| ready | input | 1 | Memory ready; low at T2/TW inserts wait states |
| holdReq | input | 1 | External bus-hold request |
| intReq | input | 1 | Interrupt request |
| intEnable | input | 1 | Interrupt-enable flag |
| lastCycle | input | 1 | Current machine cycle is the last of its instruction |
| haltInstr | input | 1 | Halt instruction executed in the current machine cycle |
| stateCount | input | CNT_W | Active states needed by the current machine cycle (3..5) |
| state | output | 3 | Current state code (see R3) |
| sync | output | 1 | High during T1 |
| hlda | output | 1 | Hold acknowledge |
| haltAck | output | 1 | Halt acknowledge |
| busFloat | output | 1 | Address and data outputs floated (HOLD or HALT) |
| intCycle | output | 1 | Current machine cycle is an interrupt cycle |
| pcIncEn | output | 1 | Program counter may advance in this T1 |

## Verification
Every input is sampled at the clock edge where `tick` is high. The new state appears right after that edge. `sync`, `hlda`, `haltAck`, `busFloat` and `pcIncEn` are decoded from the state register with no further delay, and `intCycle` changes at the same edge as the state that ends the cycle. For this reason the bench changes its inputs 1 ns after a rising edge and compares every output 1 ns after the next rising edge. It checks one state per edge against a trace it builds from the state count, the wait count and the request pattern of each cycle. The sweep covers state counts 2 to 7 and wait runs of 0 to 3 states, and then runs directed sequences for hold, halt, interrupt, reset and stalled ticks.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

  localparam int STATE_W = 3;
  // Highest state count that still ends the cycle after T3 / after T4.
  localparam int EXIT_AT_T3 = 3;
  localparam int EXIT_AT_T4 = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_T1   = 3'd0,
    ST_T2   = 3'd1,
    ST_TW   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4,
    ST_T5   = 3'd5,
    ST_HALT = 3'd6,
    ST_HOLD = 3'd7
  } tState_e;

  // Tick-qualified strobes from control to the flag datapath.
  typedef struct packed {
    logic cycleEnd;
    logic haltEntry;
    logic haltWake;
    logic holdFromHalt;
    logic holdExit;
  } tStrobe_t;

endpackage

// File: rtl/tseq_ctrl.sv
module tseq_ctrl
  import tseq_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ready,
  input  logic             holdReq,
  input  logic             intReq,
  input  logic             intEnable,
  input  logic [CNT_W-1:0] stateCount,
  input  logic             haltPend,
  input  logic             returnHalt,
  output tState_e          state,
  output tStrobe_t         strobe
);

  localparam logic [CNT_W-1:0] LIM_T3 = CNT_W'(EXIT_AT_T3);
  localparam logic [CNT_W-1:0] LIM_T4 = CNT_W'(EXIT_AT_T4);

  tState_e stateQ, stateD;
  logic    cycleDone;
  logic    intWake;

  assign intWake = intReq && intEnable;

  always_comb begin
    stateD    = stateQ;
    cycleDone = 1'b0;
    case (stateQ)
      ST_T1:   stateD = ST_T2;
      ST_T2: begin
        if (haltPend)    stateD = ST_HALT;
        else if (!ready) stateD = ST_TW;
        else             stateD = ST_T3;
      end
      ST_TW:   if (ready) stateD = ST_T3;
      ST_T3: begin
        if (stateCount <= LIM_T3) cycleDone = 1'b1;
        else                      stateD = ST_T4;
      end
      ST_T4: begin
        if (stateCount <= LIM_T4) cycleDone = 1'b1;
        else                      stateD = ST_T5;
      end
      ST_T5:   cycleDone = 1'b1;
      ST_HALT: begin
        if (holdReq)      stateD = ST_HOLD;
        else if (intWake) stateD = ST_T1;
      end
      ST_HOLD: if (!holdReq) stateD = returnHalt ? ST_HALT : ST_T1;
      default: stateD = ST_T1;
    endcase
    if (cycleDone) stateD = holdReq ? ST_HOLD : ST_T1;
  end

  always_comb begin
    strobe              = '0;
    strobe.cycleEnd     = tick && cycleDone;
    strobe.haltEntry    = tick && (stateQ == ST_T2) && haltPend;
    strobe.haltWake     = tick && (stateQ == ST_HALT) && !holdReq && intWake;
    strobe.holdFromHalt = tick && (stateQ == ST_HALT) && holdReq;
    strobe.holdExit     = tick && (stateQ == ST_HOLD) && !holdReq;
  end

  always_ff @(posedge clk) begin
    if (rst)       stateQ <= ST_T1;
    else if (tick) stateQ <= stateD;
  end

  assign state = stateQ;

endmodule

// File: rtl/tseq_flags.sv
module tseq_flags
  import tseq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  tStrobe_t strobe,
  input  logic     lastCycle,
  input  logic     intReq,
  input  logic     intEnable,
  input  logic     haltInstr,
  output logic     intCycle,
  output logic     haltPend,
  output logic     returnHalt
);

  logic intCycleQ, haltPendQ, returnHaltQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      intCycleQ   <= 1'b0;
      haltPendQ   <= 1'b0;
      returnHaltQ <= 1'b0;
    end else begin
      if (strobe.cycleEnd) begin
        intCycleQ <= lastCycle && intReq && intEnable;
        haltPendQ <= haltInstr;
      end
      if (strobe.haltEntry) begin
        haltPendQ <= 1'b0;
        intCycleQ <= 1'b0;
      end
      if (strobe.haltWake)     intCycleQ   <= 1'b1;
      if (strobe.holdFromHalt) returnHaltQ <= 1'b1;
      if (strobe.holdExit)     returnHaltQ <= 1'b0;
    end
  end

  assign intCycle   = intCycleQ;
  assign haltPend   = haltPendQ;
  assign returnHalt = returnHaltQ;

endmodule

// File: rtl/tstate_sequencer.sv
module tstate_sequencer
  import tseq_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ready,
  input  logic             holdReq,
  input  logic             intReq,
  input  logic             intEnable,
  input  logic             lastCycle,
  input  logic             haltInstr,
  input  logic [CNT_W-1:0] stateCount,
  output logic [STATE_W-1:0] state,
  output logic             sync,
  output logic             hlda,
  output logic             haltAck,
  output logic             busFloat,
  output logic             intCycle,
  output logic             pcIncEn
);

  tState_e  curState;
  tStrobe_t strobe;
  logic     haltPend, returnHalt;

  tseq_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .ready      (ready),
    .holdReq    (holdReq),
    .intReq     (intReq),
    .intEnable  (intEnable),
    .stateCount (stateCount),
    .haltPend   (haltPend),
    .returnHalt (returnHalt),
    .state      (curState),
    .strobe     (strobe)
  );

  tseq_flags flags_i (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .lastCycle  (lastCycle),
    .intReq     (intReq),
    .intEnable  (intEnable),
    .haltInstr  (haltInstr),
    .intCycle   (intCycle),
    .haltPend   (haltPend),
    .returnHalt (returnHalt)
  );

  assign state    = curState;
  assign sync     = (curState == ST_T1);
  assign hlda     = (curState == ST_HOLD);
  assign haltAck  = (curState == ST_HALT);
  assign busFloat = (curState == ST_HOLD) || (curState == ST_HALT);
  assign pcIncEn  = (curState == ST_T1) && !intCycle;

endmodule

// File: rtl/tstate_sequencer_chk.sv
module tstate_sequencer_chk
  import tseq_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic               holdReq,
  input logic               intEnable,
  input logic [STATE_W-1:0] state,
  input logic               sync,
  input logic               hlda,
  input logic               busFloat,
  input logic               intCycle,
  input logic               pcIncEn
);

  AST_RESET_TO_T1: assert property (@(posedge clk)
    rst |=> (state == ST_T1) && !intCycle);                                  // R1

  AST_TICK_STALL: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(state));                                               // R2

  AST_T1_TO_T2: assert property (@(posedge clk) disable iff (rst)
    (tick && state == ST_T1) |=> state == ST_T2);                            // R3

  AST_NO_WAIT_OUTSIDE_T2: assert property (@(posedge clk) disable iff (rst)
    (tick && state != ST_T2 && state != ST_TW) |=> state != ST_TW);          // R3

  AST_SYNC_ONE_STATE: assert property (@(posedge clk) disable iff (rst)
    (tick && sync) |=> !sync);                                               // R5

  AST_HOLD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (tick && (state == ST_T1 || state == ST_T2 || state == ST_TW))
      |=> state != ST_HOLD);                                                 // R6

  AST_HLDA_FLOATS: assert property (@(posedge clk) disable iff (rst)
    hlda |-> busFloat);                                                      // R6

  AST_INT_NO_PC: assert property (@(posedge clk) disable iff (rst)
    (sync && intCycle) |-> !pcIncEn);                                        // R7

  AST_HALT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (tick && state == ST_HALT && !holdReq && !intEnable) |=> state == ST_HALT); // R9

endmodule

bind tstate_sequencer tstate_sequencer_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .holdReq   (holdReq),
  .intEnable (intEnable),
  .state     (state),
  .sync      (sync),
  .hlda      (hlda),
  .busFloat  (busFloat),
  .intCycle  (intCycle),
  .pcIncEn   (pcIncEn)
);

// File: tb/tstate_sequencer_tb_top.sv
`timescale 1ns/1ps
module tstate_sequencer_tb_top;

  localparam int S_T1 = 0, S_T2 = 1, S_TW = 2, S_T3 = 3;
  localparam int S_T4 = 4, S_T5 = 5, S_HALT = 6, S_HOLD = 7;

  logic clk = 1'b0;
  logic rst = 1'b1, tick = 1'b1, ready = 1'b1, holdReq = 1'b0;
  logic intReq = 1'b0, intEnable = 1'b0, lastCycle = 1'b0, haltInstr = 1'b0;
  logic [2:0] stateCount = 3'd3;
  logic [2:0] state;
  logic sync, hlda, haltAck, busFloat, intCycle, pcIncEn;

  int nVec = 0;
  int nBad = 0;
  bit expInt = 1'b0;

  always #4 clk = ~clk;

  tstate_sequencer dut_i (
    .clk(clk), .rst(rst), .tick(tick), .ready(ready), .holdReq(holdReq),
    .intReq(intReq), .intEnable(intEnable), .lastCycle(lastCycle),
    .haltInstr(haltInstr), .stateCount(stateCount), .state(state),
    .sync(sync), .hlda(hlda), .haltAck(haltAck), .busFloat(busFloat),
    .intCycle(intCycle), .pcIncEn(pcIncEn)
  );

  task automatic check(string req, int act, int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic adv();
    @(posedge clk);
    #1;
  endtask

  task automatic chkState(string req, int exp);
    check(req, int'(state), exp);
    check("R5 sync", int'(sync), int'(exp == S_T1));
    check("R6 hlda", int'(hlda), int'(exp == S_HOLD));
    check("R8 haltAck", int'(haltAck), int'(exp == S_HALT));
    check("R6 busFloat", int'(busFloat), int'(exp == S_HOLD || exp == S_HALT));
  endtask

  // Runs one machine cycle from T1; ends in T1 or HOLD.
  task automatic runCycle(int n, int w, bit lastC, bit irq, bit ie, bit hlt, bit hld);
    stateCount = 3'(n);
    intReq = irq; intEnable = ie; holdReq = hld;
    lastCycle = 1'b0; haltInstr = 1'b0;
    chkState("R3 T1", S_T1);
    check("R7 pcIncEn", int'(pcIncEn), int'(!expInt));
    check("R7 intCycle", int'(intCycle), int'(expInt));
    ready = (w == 0);
    adv(); chkState("R3 T2", S_T2);
    adv();
    for (int i = 0; i < w; i++) begin
      chkState("R3 TW", S_TW);
      ready = (i == w - 1);
      adv();
    end
    chkState("R3 T3", S_T3);
    if (n > 3) begin adv(); chkState("R4 T4", S_T4); end
    if (n > 4) begin adv(); chkState("R4 T5", S_T5); end
    lastCycle = lastC; haltInstr = hlt;
    adv();
    expInt = lastC && irq && ie;
    chkState(hld ? "R6 hold at end" : "R4 exit", hld ? S_HOLD : S_T1);
    check("R7 latch", int'(intCycle), int'(expInt));
    lastCycle = 1'b0; haltInstr = 1'b0; ready = 1'b1; intReq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    // R1 reset state, also with tick low
    tick = 1'b0;
    adv(); adv();
    chkState("R1 reset", S_T1);
    check("R1 intCycle", int'(intCycle), 0);
    tick = 1'b1; rst = 1'b0;

    // R3/R4 sweep: state counts 2..7, waits 0..3
    for (int n = 2; n <= 7; n++)
      for (int w = 0; w <= 3; w++)
        runCycle(n, w, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R2 stalled tick in T2 and TW
    ready = 1'b0; stateCount = 3'd3;
    adv(); chkState("R2", S_T2);
    tick = 1'b0;
    for (int i = 0; i < 3; i++) begin adv(); chkState("R2 stall", S_T2); end
    tick = 1'b1; adv(); chkState("R2 resume", S_TW);
    tick = 1'b0; ready = 1'b1;
    adv(); chkState("R2 stall TW", S_TW);
    tick = 1'b1; adv(); chkState("R2", S_T3);
    adv(); chkState("R4", S_T1);

    // R7 interrupt latching
    runCycle(3, 0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0); // not last: no latch
    runCycle(4, 1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); // disabled: no latch
    runCycle(5, 0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // latched
    runCycle(3, 2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // int cycle, then cleared

    // R6 hold at boundary, with interrupt latched across it (R7)
    runCycle(4, 1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    intReq = 1'b1; intEnable = 1'b1;
    for (int i = 0; i < 3; i++) begin adv(); chkState("R6 hold stays", S_HOLD); end
    holdReq = 1'b0; intReq = 1'b0;
    adv(); chkState("R6 hold exit", S_T1);
    check("R7 kept over hold", int'(intCycle), 1);
    runCycle(3, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R8 halt entry, R9 exits, R10 priority
    runCycle(3, 0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    ready = 1'b0;
    adv(); chkState("R8 T2", S_T2);
    adv(); chkState("R8 halt", S_HALT);
    intReq = 1'b1; intEnable = 1'b0;
    for (int i = 0; i < 3; i++) begin adv(); chkState("R9 locked", S_HALT); end
    holdReq = 1'b1; intEnable = 1'b1;
    adv(); chkState("R10 hold over int", S_HOLD);
    adv(); chkState("R9 hold", S_HOLD);
    holdReq = 1'b0; intReq = 1'b0;
    adv(); chkState("R9 back to halt", S_HALT);
    intReq = 1'b1;
    adv(); chkState("R9 int wake", S_T1);
    check("R9 intCycle", int'(intCycle), 1);
    check("R7 pcIncEn", int'(pcIncEn), 0);
    expInt = 1'b1;
    runCycle(3, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R1/R10 reset during hold taken from halt clears return-to-halt
    runCycle(3, 0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    adv(); adv(); chkState("R8 halt", S_HALT);
    holdReq = 1'b1;
    adv(); chkState("R9 hold", S_HOLD);
    rst = 1'b1;
    adv(); chkState("R1 reset over hold", S_T1);
    rst = 1'b0; holdReq = 1'b0; expInt = 1'b0;
    runCycle(3, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    holdReq = 1'b0;
    adv(); chkState("R1 return flag cleared", S_T1);

    // R1 reset out of halt with interrupts disabled
    runCycle(5, 0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    adv(); adv(); chkState("R8 halt", S_HALT);
    rst = 1'b1;
    adv(); chkState("R1 reset from halt", S_T1);
    rst = 1'b0;
    runCycle(3, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule